// File: doc/BRIEF.md
# Reset-Time Configuration ID Autoloader

This block runs once after every reset. It reads three consecutive 16-bit words from a nonvolatile store through a word-read port that uses a request/acknowledge handshake. The first word is a control word. Its top two bits hold a presence signature and bit 13 is an option bit. The second word holds a Subsystem ID and the third holds a Subsystem Vendor ID. From these words the block sets the identity values that a configuration-space register file presents to the host: Subsystem ID, Subsystem Vendor ID and Revision ID. It also presents a Device ID and a Vendor ID, which are fixed by parameters, and a hard-wired capability pointer byte.

Until the third word has been captured, the block raises a retry indication. The configuration access logic uses it to answer every host access with a Retry, so the host never sees half-loaded identity values. Once the load completes, a done flag rises and stays high until the next reset.

Top module: `cfg_id_autoload`

## Requirements
- R1: One cycle after reset is released, the block asserts `nvm_req`. It fetches word addresses 0xA, 0xB and 0xC, in that order. Each request and its address stay unchanged until `nvm_ack` is sampled high.
- R2: `cfg_retry` is 1 from reset until `load_done` rises, and it is 0 from then on.
- R3: `load_done` is 0 during reset. It rises in the cycle that follows the clock edge that samples the acknowledge for word 0xC, and it then stays 1 until reset.
- R4: If bits 15:14 of word 0xA equal 2'b01, then once the load is done `subsys_id` equals word 0xB and `subsys_ven_id` equals word 0xC. This holds for either value of bit 13.
- R5: If bits 15:14 of word 0xA equal 2'b00, 2'b10 or 2'b11, then `subsys_id` and `subsys_ven_id` stay 16'h0000 and `rev_id` stays at its default of 8'h09.
- R6: If bits 15:14 equal 2'b01 and bit 13 is 1, `rev_id[2:0]` takes bits 10:8 of word 0xA and `rev_id[7:3]` keeps its default bits (5'b00001).
- R7: If bits 15:14 equal 2'b01 and bit 13 is 0, `rev_id` stays 8'h09.
- R8: `dev_id` (default 16'h4A17), `ven_id` (default 16'h1F2E) and `cap_ptr` (8'hDC) never change, whatever the load does.
- R9: Until the load is done, `subsys_id` and `subsys_ven_id` read 16'h0000 and `rev_id` reads 8'h09.
- R10: An acknowledge that arrives while `nvm_req` is low has no effect. It neither advances the fetch nor changes any ID output.
- R11: After `load_done` rises, no further request is issued.
- R12: A reset in the middle of the load restarts the fetch from address 0xA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nvm_req | output | 1 | Word read request to the nonvolatile store |
| nvm_addr | output | 4 | Word address of the current request |
| nvm_ack | input | 1 | Read data valid, acknowledges the request |
| nvm_rdata | input | 16 | Read data, valid with `nvm_ack` |
| cfg_retry | output | 1 | Configuration access logic must answer with Retry |
| load_done | output | 1 | Autoload has completed |
| dev_id | output | 16 | Device ID |
| ven_id | output | 16 | Vendor ID |
| rev_id | output | 8 | Revision ID |
| subsys_id | output | 16 | Subsystem ID |
| subsys_ven_id | output | 16 | Subsystem Vendor ID |
| cap_ptr | output | 8 | Capability pointer byte |

## Verification
The first request appears one cycle after reset is released. Each following request is visible in the cycle right after the edge that sampled the previous acknowledge. All ID outputs, `load_done` and `cfg_retry` take their final values in the cycle after the edge that samples the third acknowledge. The bench drives the acknowledge and the data on falling edges and samples every output on the next falling edge. As a result, each check falls exactly one register stage after its stimulus. While an acknowledge is held back, the bench checks on each falling edge that the request and address stay put. After the load, it watches several further cycles to confirm that nothing moves.

// File: rtl/autoload_pkg.sv
package autoload_pkg;

  localparam int unsigned CTL_W = 16;

  typedef enum logic [1:0] {
    AL_IDLE  = 2'd0,
    AL_FETCH = 2'd1,
    AL_DONE  = 2'd2
  } al_state_e;

  // Presence signature lives in the two top bits of the control word.
  function automatic logic sig_present(input logic [CTL_W-1:0] ctl);
    return (ctl[15:14] == 2'b01);
  endfunction

  // Revision override needs a valid signature plus the option bit.
  function automatic logic rev_override(input logic [CTL_W-1:0] ctl);
    return sig_present(ctl) && ctl[13];
  endfunction

  function automatic logic [7:0] merge_rev(input logic [7:0] def,
                                           input logic [CTL_W-1:0] ctl);
    return rev_override(ctl) ? {def[7:3], ctl[10:8]} : def;
  endfunction

endpackage

// File: rtl/autoload_seq.sv
module autoload_seq
  import autoload_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned NUM_WORDS = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 4'hA,
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              last_cap,
  output logic              done
);

  al_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign req      = (state_q == AL_FETCH);
  assign addr     = BASE_ADDR + ADDR_W'(idx_q);
  assign cap_en   = req && ack;
  assign cap_idx  = idx_q;
  assign last_cap = cap_en && (idx_q == IDX_W'(NUM_WORDS - 1));
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= AL_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        AL_IDLE: state_q <= AL_FETCH;
        AL_FETCH: begin
          if (last_cap) begin
            state_q <= AL_DONE;
            done_q  <= 1'b1;
          end else if (cap_en) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        AL_DONE: state_q <= AL_DONE;
        default: state_q <= AL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/autoload_word_store.sv
module autoload_word_store #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 3,
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cap_en,
  input  logic [IDX_W-1:0]                  cap_idx,
  input  logic [WORD_W-1:0]                 rdata,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= '0;
      else if (cap_en && (cap_idx == IDX_W'(g)))
        slot_q <= rdata;
    end
    assign words[g] = slot_q;
  end

endmodule

// File: rtl/autoload_id_decode.sv
module autoload_id_decode
  import autoload_pkg::*;
#(
  parameter logic [7:0] REV_DEFAULT = 8'h09
) (
  input  logic             done,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic [15:0]      ssid_word,
  input  logic [15:0]      ssvid_word,
  output logic             sig_ok,
  output logic [15:0]      subsys_id,
  output logic [15:0]      subsys_ven_id,
  output logic [7:0]       rev_id
);

  always_comb begin
    sig_ok        = sig_present(ctl_word);
    subsys_id     = 16'h0000;
    subsys_ven_id = 16'h0000;
    rev_id        = REV_DEFAULT;
    if (done) begin
      rev_id = merge_rev(REV_DEFAULT, ctl_word);
      if (sig_ok) begin
        subsys_id     = ssid_word;
        subsys_ven_id = ssvid_word;
      end
    end
  end

endmodule

// File: rtl/cfg_id_autoload.sv
module cfg_id_autoload
  import autoload_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 4'hA,
  parameter logic [15:0] DEV_ID      = 16'h4A17,
  parameter logic [15:0] VEN_ID      = 16'h1F2E,
  parameter logic [7:0]  REV_DEFAULT = 8'h09,
  parameter logic [7:0]  CAP_PTR     = 8'hDC
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              nvm_req,
  output logic [ADDR_W-1:0] nvm_addr,
  input  logic              nvm_ack,
  input  logic [15:0]       nvm_rdata,
  output logic              cfg_retry,
  output logic              load_done,
  output logic [15:0]       dev_id,
  output logic [15:0]       ven_id,
  output logic [7:0]        rev_id,
  output logic [15:0]       subsys_id,
  output logic [15:0]       subsys_ven_id,
  output logic [7:0]        cap_ptr
);

  localparam int unsigned NUM_WORDS = 3;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

  logic                           cap_en;
  logic [IDX_W-1:0]               cap_idx;
  logic                           last_cap;
  logic                           done;
  logic                           sig_ok;
  logic [NUM_WORDS-1:0][15:0]     words;

  autoload_seq #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .BASE_ADDR (BASE_ADDR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (nvm_ack),
    .req      (nvm_req),
    .addr     (nvm_addr),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .last_cap (last_cap),
    .done     (done)
  );

  autoload_word_store #(
    .WORD_W    (16),
    .NUM_WORDS (NUM_WORDS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .rdata   (nvm_rdata),
    .words   (words)
  );

  autoload_id_decode #(
    .REV_DEFAULT (REV_DEFAULT)
  ) u_dec (
    .done          (done),
    .ctl_word      (words[0]),
    .ssid_word     (words[1]),
    .ssvid_word    (words[2]),
    .sig_ok        (sig_ok),
    .subsys_id     (subsys_id),
    .subsys_ven_id (subsys_ven_id),
    .rev_id        (rev_id)
  );

  assign load_done = done;
  assign cfg_retry = ~done;
  assign dev_id    = DEV_ID;
  assign ven_id    = VEN_ID;
  assign cap_ptr   = CAP_PTR;

endmodule

// File: rtl/autoload_chk.sv
module autoload_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 4'hA,
  parameter logic [7:0] REV_DEFAULT = 8'h09
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nvm_req,
  input logic [ADDR_W-1:0] nvm_addr,
  input logic              nvm_ack,
  input logic              load_done,
  input logic              cfg_retry,
  input logic [15:0]       subsys_id,
  input logic [15:0]       subsys_ven_id,
  input logic [7:0]        rev_id,
  input logic              sig_ok,
  input logic              last_cap,
  input logic [15:0]       ctl_word
);

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req && !nvm_ack |=> nvm_req && $stable(nvm_addr));

  assert_addr_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req && nvm_ack && (nvm_addr == BASE_ADDR) |=>
      nvm_req && (nvm_addr == BASE_ADDR + ADDR_W'(1)));

  assert_retry_while_loading_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req |-> cfg_retry && !load_done);

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_cap |=> load_done && !cfg_retry);

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  assert_absent_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && !sig_ok |->
      (subsys_id == 16'h0000) && (subsys_ven_id == 16'h0000) && (rev_id == REV_DEFAULT));

  assert_rev_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && sig_ok && ctl_word[13] |->
      (rev_id[7:3] == REV_DEFAULT[7:3]) && (rev_id[2:0] == ctl_word[10:8]));

  assert_rev_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_word[13] |-> rev_id == REV_DEFAULT);

  assert_pre_done_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (subsys_id == 16'h0000) && (subsys_ven_id == 16'h0000));

  assert_no_req_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !nvm_req);

endmodule

bind cfg_id_autoload autoload_chk #(
  .ADDR_W      (ADDR_W),
  .BASE_ADDR   (BASE_ADDR),
  .REV_DEFAULT (REV_DEFAULT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nvm_req       (nvm_req),
  .nvm_addr      (nvm_addr),
  .nvm_ack       (nvm_ack),
  .load_done     (load_done),
  .cfg_retry     (cfg_retry),
  .subsys_id     (subsys_id),
  .subsys_ven_id (subsys_ven_id),
  .rev_id        (rev_id),
  .sig_ok        (sig_ok),
  .last_cap      (last_cap),
  .ctl_word      (words[0])
);

// File: tb/cfg_id_autoload_bench.sv
module cfg_id_autoload_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nvm_req;
  logic [3:0]  nvm_addr;
  logic        nvm_ack = 1'b0;
  logic [15:0] nvm_rdata = 16'h0000;
  logic        cfg_retry, load_done;
  logic [15:0] dev_id, ven_id, subsys_id, subsys_ven_id;
  logic [7:0]  rev_id, cap_ptr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_id_autoload u_cfg_id_autoload (
    .clk(clk), .rst_n(rst_n), .nvm_req(nvm_req), .nvm_addr(nvm_addr),
    .nvm_ack(nvm_ack), .nvm_rdata(nvm_rdata), .cfg_retry(cfg_retry),
    .load_done(load_done), .dev_id(dev_id), .ven_id(ven_id), .rev_id(rev_id),
    .subsys_id(subsys_id), .subsys_ven_id(subsys_ven_id), .cap_ptr(cap_ptr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rev(input logic [15:0] w0);
    if (w0[15] == 1'b0 && w0[14] == 1'b1 && w0[13] == 1'b1)
      return {5'b00001, w0[10:8]};
    return 8'h09;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    nvm_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset done", {15'd0, load_done}, 16'd0);
    chk("R2 reset retry", {15'd0, cfg_retry}, 16'd1);
    chk("R1 reset req", {15'd0, nvm_req}, 16'd0);
    rst_n = 1'b1;
  endtask

  task automatic serve(input logic [3:0] a, input logic [15:0] d, input int waits);
    int t = 0;
    while (!nvm_req && t < 20) begin
      @(negedge clk);
      t++;
    end
    chk("R1 request seen", {15'd0, nvm_req}, 16'd1);
    chk("R1 address", {12'd0, nvm_addr}, {12'd0, a});
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R1 hold req", {15'd0, nvm_req}, 16'd1);
      chk("R1 hold addr", {12'd0, nvm_addr}, {12'd0, a});
      chk("R2 retry during load", {15'd0, cfg_retry}, 16'd1);
    end
    nvm_ack = 1'b1;
    nvm_rdata = d;
    @(negedge clk);
    nvm_ack = 1'b0;
    nvm_rdata = 16'h0000;
  endtask

  task automatic check_final(input logic [15:0] w0, input logic [15:0] w1,
                             input logic [15:0] w2);
    logic present;
    present = (w0[15:14] == 2'b01);
    chk("R3 done", {15'd0, load_done}, 16'd1);
    chk("R2 retry off", {15'd0, cfg_retry}, 16'd0);
    chk(present ? "R4 ssid" : "R5 ssid", subsys_id, present ? w1 : 16'h0000);
    chk(present ? "R4 ssvid" : "R5 ssvid", subsys_ven_id, present ? w2 : 16'h0000);
    chk(w0[13] ? "R6 rev" : "R7 rev", {8'd0, rev_id}, {8'd0, exp_rev(w0)});
    chk("R8 dev", dev_id, 16'h4A17);
    chk("R8 ven", ven_id, 16'h1F2E);
    chk("R8 cap", {8'd0, cap_ptr}, 16'h00DC);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R11 no req", {15'd0, nvm_req}, 16'd0);
      chk("R3 sticky", {15'd0, load_done}, 16'd1);
    end
  endtask

  task automatic run_load(input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] w2, input int waits);
    do_reset();
    serve(4'hA, w0, waits);
    serve(4'hB, w1, waits);
    chk("R9 ssid pre", subsys_id, 16'h0000);
    chk("R9 rev pre", {8'd0, rev_id}, 16'h0009);
    chk("R2 retry pre", {15'd0, cfg_retry}, 16'd1);
    serve(4'hC, w2, waits);
    check_final(w0, w1, w2);
  endtask

  task automatic t_present_override();
    run_load(16'h6500, 16'h1234, 16'hABCD, 0);
  endtask

  task automatic t_present_plain();
    run_load(16'h4700, 16'h5555, 16'hA0A0, 2);
  endtask

  task automatic t_absent_all();
    logic [1:0] sig [3] = '{2'b00, 2'b10, 2'b11};
    for (int k = 0; k < 3; k++)
      run_load({sig[k], 14'h3700}, 16'hBEEF, 16'hCAFE, 1);
  endtask

  task automatic t_slow_ack();
    run_load(16'h6200, 16'hFFFF, 16'h0001, 6);
  endtask

  task automatic t_spurious_ack();
    do_reset();
    nvm_ack = 1'b1;
    nvm_rdata = 16'h0000;
    @(negedge clk);
    nvm_ack = 1'b0;
    chk("R10 addr after early ack", {12'd0, nvm_addr}, 16'h000A);
    serve(4'hA, 16'h6300, 0);
    serve(4'hB, 16'h0F0F, 0);
    serve(4'hC, 16'hF0F0, 0);
    check_final(16'h6300, 16'h0F0F, 16'hF0F0);
    nvm_ack = 1'b1;
    nvm_rdata = 16'h9999;
    @(negedge clk);
    nvm_ack = 1'b0;
    @(negedge clk);
    chk("R10 ssid unchanged", subsys_id, 16'h0F0F);
    chk("R10 ssvid unchanged", subsys_ven_id, 16'hF0F0);
    chk("R10 rev unchanged", {8'd0, rev_id}, 16'h000B);
    chk("R10 no req", {15'd0, nvm_req}, 16'd0);
  endtask

  task automatic t_midload_reset();
    do_reset();
    serve(4'hA, 16'h6100, 0);
    serve(4'hB, 16'h7777, 0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    serve(4'hA, 16'h4000, 0);
    serve(4'hB, 16'h2222, 0);
    serve(4'hC, 16'h3333, 0);
    chk("R12 restart rev", {8'd0, rev_id}, 16'h0009);
    check_final(16'h4000, 16'h2222, 16'h3333);
  endtask

  initial begin
    t_present_override();
    t_present_plain();
    t_absent_all();
    t_slow_ack();
    t_spurious_ack();
    t_midload_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule